// File: doc/BRIEF.md
# Fixed-Point Wrapping Multiply-Accumulate Unit

This block is the arithmetic heart of an audio filtering datapath. Each cycle that its operand strobe is high, it multiplies a signed 32-bit data word in 9.23 fixed point by a signed 28-bit coefficient in 5.23 fixed point. The full 60-bit product has 14 integer bits and 46 fraction bits. That product is either added to a 60-bit accumulator or loaded into it. A sequencer outside the block runs a filter such as a direct-form-I biquad by streaming its taps through, asserting the clear control on the first tap of each sum so that consecutive sums run back to back.

The accumulator uses two's-complement wraparound and never saturates. Partial sums may overflow along the way, and the final value is still exact whenever the true result fits. Next to the full accumulator the block gives a 9.23 view of it, formed by truncation. A small combinational helper places 16-, 18-, 20- or 24-bit signed audio samples into the 32-bit word format. Four guard bits sit at the top of that word and four precision bits at the bottom.

Top module: `wrap_mac`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `acc_out` is zero and `result_valid` is low.
- R2: With `op_valid` and `acc_clear` both high, the accumulator is loaded on that clock edge with the exact 60-bit signed product of `data_in` (32-bit two's complement) and `coef_in` (28-bit two's complement). The old accumulator value is discarded.
- R3: With `op_valid` high and `acc_clear` low, the accumulator becomes its old value plus the sign-extended product, taken modulo 2^60.
- R4: Overflow never saturates. A run of terms whose partial sums pass the 60-bit range, but whose true total fits, leaves the exact total in the accumulator.
- R5: With `acc_clear` high and `op_valid` low, the accumulator becomes zero.
- R6: With both `op_valid` and `acc_clear` low, the accumulator keeps its value, whatever `data_in` and `coef_in` carry.
- R7: `result_valid` is high in exactly the cycle after each cycle in which `op_valid` was high, and low otherwise.
- R8: `result_out` equals accumulator bits 54 down to 23. This is the 9.23 value truncated toward minus infinity, with the bits above 54 dropped so that it wraps.
- R9: `smp_word` is the aligned sample. `smp_fmt` selects the width: 0 = 16 bits, 1 = 18 bits, 2 = 20 bits, 3 = 24 bits. The sample is the low-order bits of `smp_in` for that width, treated as signed. It is placed with its MSB at bit 27, bits 31..28 copy its sign, and the bits below it are zero.
- R10: Two sums can follow each other with no idle cycle. A clear-with-valid cycle directly after an accumulating cycle starts the new sum from its own product alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operand pair present this cycle |
| acc_clear | input | 1 | Start a new sum (load instead of add) |
| data_in | input | 32 | Signed 9.23 data operand |
| coef_in | input | 28 | Signed 5.23 coefficient |
| acc_out | output | 60 | Full-precision accumulator |
| result_out | output | 32 | Accumulator truncated to 9.23 |
| result_valid | output | 1 | Accumulator updated by an operand last cycle |
| smp_in | input | 24 | Raw audio sample, low bits used |
| smp_fmt | input | 2 | Sample width select |
| smp_word | output | 32 | Sample aligned into the data word |

## Verification
The bench builds the block with its default widths: 32-bit data, 28-bit coefficients and a 60-bit accumulator equal to the product width. At these widths, products of full-scale operands come close to 2^58, so four of them are enough to carry the accumulator past its range and back. The bench uses this to exercise the wrap, which is then undone by terms of the opposite sign. The same widths place the 9.23 view at bits 54..23, so accumulators with bits set above 54 show the truncated result wrapping. Every one of the four sample widths is driven with positive and negative extremes.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [1:0] {
      FMT_16 = 2'd0,
      FMT_18 = 2'd1,
      FMT_20 = 2'd2,
      FMT_24 = 2'd3
   } smp_fmt_e;

   localparam int NUM_FMTS = 4;

   function automatic int fmt_width(input int idx);
      case (idx)
         0:       return 16;
         1:       return 18;
         2:       return 20;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int DATA_W = 32,
   parameter int COEF_W = 28,
   localparam int PROD_W = DATA_W + COEF_W
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [COEF_W-1:0] coef_i,
   output logic [PROD_W-1:0] prod_o
);

   logic signed [PROD_W-1:0] a_ext;
   logic signed [PROD_W-1:0] b_ext;

   assign a_ext  = {{COEF_W{data_i[DATA_W-1]}}, data_i};
   assign b_ext  = {{DATA_W{coef_i[COEF_W-1]}}, coef_i};
   assign prod_o = a_ext * b_ext;

endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
   parameter int PROD_W = 60,
   parameter int ACC_W  = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              acc_clear,
   input  logic [PROD_W-1:0] prod_i,
   output logic [ACC_W-1:0]  acc_o,
   output logic              valid_o
);

   logic [ACC_W-1:0] prod_ext;

   generate
      if (ACC_W > PROD_W) begin : g_sext
         assign prod_ext = {{(ACC_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
      end else begin : g_same
         assign prod_ext = prod_i[ACC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o   <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= op_valid;
         if (op_valid && acc_clear)
            acc_o <= prod_ext;
         else if (op_valid)
            acc_o <= acc_o + prod_ext;
         else if (acc_clear)
            acc_o <= '0;
      end
   end

   // R3
   add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !acc_clear) |=> (acc_o == $past(acc_o) + $past(prod_ext)));

   // R2
   load_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && acc_clear) |=> (acc_o == $past(prod_ext)));

   // R5
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_clear && !op_valid) |=> (acc_o == '0));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !acc_clear) |=> $stable(acc_o));

   // R7
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> valid_o);

   // R7
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !valid_o);

endmodule

// File: rtl/sample_align.sv
module sample_align #(
   parameter int DATA_W   = 32,
   parameter int GUARD_W  = 4,
   parameter int SMP_W    = 24,
   localparam int TOP_BIT = DATA_W - GUARD_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SMP_W-1:0]  smp_in,
   input  logic [1:0]        smp_fmt,
   output logic [DATA_W-1:0] smp_word
);

   logic [mac_pkg::NUM_FMTS-1:0][DATA_W-1:0] cand;
   logic [mac_pkg::NUM_FMTS-1:0]             cand_sign;

   generate
      for (genvar i = 0; i < mac_pkg::NUM_FMTS; i++) begin : g_fmt
         localparam int W = mac_pkg::fmt_width(i);
         if (W > SMP_W || W > TOP_BIT + 1) begin : g_bad
            $error("sample width exceeds input or word");
         end
         assign cand_sign[i] = smp_in[W-1];
         assign cand[i] = {{GUARD_W{smp_in[W-1]}}, smp_in[W-1:0],
                           {(TOP_BIT+1-W){1'b0}}};
      end
   endgenerate

   assign smp_word = cand[smp_fmt];

   // R9
   sign_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_word[DATA_W-1] == cand_sign[smp_fmt]);

endmodule

// File: rtl/wrap_mac.sv
module wrap_mac #(
   parameter int DATA_W    = 32,
   parameter int DATA_FRAC = 23,
   parameter int COEF_W    = 28,
   parameter int COEF_FRAC = 23,
   parameter int ACC_W     = 60,
   parameter int GUARD_W   = 4,
   parameter int SMP_W     = 24,
   localparam int PROD_W   = DATA_W + COEF_W,
   localparam int RES_LSB  = COEF_FRAC,
   localparam int RES_MSB  = COEF_FRAC + DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              acc_clear,
   input  logic [DATA_W-1:0] data_in,
   input  logic [COEF_W-1:0] coef_in,
   output logic [ACC_W-1:0]  acc_out,
   output logic [DATA_W-1:0] result_out,
   output logic              result_valid,
   input  logic [SMP_W-1:0]  smp_in,
   input  logic [1:0]        smp_fmt,
   output logic [DATA_W-1:0] smp_word
);

   generate
      if (ACC_W < PROD_W) begin : g_acc_chk
         $error("accumulator narrower than product");
      end
      if (RES_MSB >= ACC_W) begin : g_res_chk
         $error("result slice outside accumulator");
      end
      if (DATA_FRAC >= DATA_W - GUARD_W) begin : g_frac_chk
         $error("data fraction leaves no integer bits");
      end
   endgenerate

   logic [PROD_W-1:0] prod;

   mac_mult #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W)
   ) mult_i (
      .data_i (data_in),
      .coef_i (coef_in),
      .prod_o (prod)
   );

   mac_acc #(
      .PROD_W (PROD_W),
      .ACC_W  (ACC_W)
   ) acc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .acc_clear (acc_clear),
      .prod_i    (prod),
      .acc_o     (acc_out),
      .valid_o   (result_valid)
   );

   assign result_out = acc_out[RES_MSB:RES_LSB];

   sample_align #(
      .DATA_W  (DATA_W),
      .GUARD_W (GUARD_W),
      .SMP_W   (SMP_W)
   ) align_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_in   (smp_in),
      .smp_fmt  (smp_fmt),
      .smp_word (smp_word)
   );

   // R10
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && acc_clear && $past(op_valid)) |=> result_valid);

endmodule

// File: tb/wrap_mac_tb.sv
module wrap_mac_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        acc_clear = 1'b0;
   logic [31:0] data_in = '0;
   logic [27:0] coef_in = '0;
   logic [59:0] acc_out;
   logic [31:0] result_out;
   logic        result_valid;
   logic [23:0] smp_in = '0;
   logic [1:0]  smp_fmt = '0;
   logic [31:0] smp_word;

   int n_checks = 0;
   int n_fails  = 0;

   typedef struct {
      logic [59:0] acc;
      logic [31:0] res;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   logic [59:0] m_acc = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wrap_mac dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_valid     (op_valid),
      .acc_clear    (acc_clear),
      .data_in      (data_in),
      .coef_in      (coef_in),
      .acc_out      (acc_out),
      .result_out   (result_out),
      .result_valid (result_valid),
      .smp_in       (smp_in),
      .smp_fmt      (smp_fmt),
      .smp_word     (smp_word)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   function automatic logic [59:0] prod60(input logic [31:0] d, input logic [27:0] k);
      logic signed [59:0] a;
      logic signed [59:0] b;
      a = {{28{d[31]}}, d};
      b = {{32{k[27]}}, k};
      return a * b;
   endfunction

   // driver: one operation per cycle, expected item queued when valid
   task automatic drive(input bit v, input bit c, input logic [31:0] d, input logic [27:0] k, input string tag);
      exp_t e;
      @(negedge clk);
      op_valid  = v;
      acc_clear = c;
      data_in   = d;
      coef_in   = k;
      if (v && c)   m_acc = prod60(d, k);
      else if (v)   m_acc = m_acc + prod60(d, k);
      else if (c)   m_acc = '0;
      if (v) begin
         e.acc = m_acc;
         e.res = m_acc[54:23];
         e.tag = tag;
         exp_q.push_back(e);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 32'hDEAD_BEEF, 28'h5A5_A5A5, "R6");
   endtask

   // monitor: pops one expected item per valid result
   always @(negedge clk) begin
      if (rst_n) begin
         if (result_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected valid", 64'(result_valid), 64'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(acc_out == e.acc, e.tag, 64'(acc_out), 64'(e.acc));
               chk(result_out == e.res, "R8", 64'(result_out), 64'(e.res));
            end
         end
      end
   end

   task automatic chk_align(input logic [1:0] fmt, input logic [23:0] s);
      int w;
      logic [31:0] expw;
      w = (fmt == 2'd0) ? 16 : (fmt == 2'd1) ? 18 : (fmt == 2'd2) ? 20 : 24;
      expw = '0;
      for (int b = 0; b < 32; b++) begin
         if (b >= 28)            expw[b] = s[w-1];
         else if (b >= 28 - w)   expw[b] = s[b - (28 - w)];
      end
      smp_fmt = fmt;
      smp_in  = s;
      #1;
      chk(smp_word == expw, "R9", 64'(smp_word), 64'(expw));
   endtask

   initial begin
      repeat (2) @(negedge clk);
      // R1 reset state
      chk(acc_out == '0, "R1 acc", 64'(acc_out), 64'd0);
      chk(result_valid == 1'b0, "R1 valid", 64'(result_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(acc_out == '0, "R1 after release", 64'(acc_out), 64'd0);

      // R2 load, R3 accumulate
      drive(1, 1, 32'h0080_0000, 28'h080_0000, "R2");
      drive(1, 0, 32'hFF80_0000, 28'h040_0000, "R3");
      drive(1, 0, 32'h1234_5678, 28'hF00_1234, "R3");
      drive(1, 0, 32'h8000_0000, 28'h800_0000, "R3");
      idle(3);
      chk(acc_out == m_acc, "R6 hold", 64'(acc_out), 64'(m_acc));
      chk(result_valid == 1'b0, "R7 idle", 64'(result_valid), 64'd0);

      // R5 clear without valid
      drive(0, 1, 32'h7FFF_FFFF, 28'h7FF_FFFF, "R5");
      drive(0, 0, 32'h0, 28'h0, "R5");
      chk(acc_out == '0, "R5", 64'(acc_out), 64'd0);

      // R4 wrap through overflow and back
      drive(1, 1, 32'h7FFF_FFFF, 28'h7FF_FFFF, "R4");
      for (int i = 0; i < 3; i++) drive(1, 0, 32'h7FFF_FFFF, 28'h7FF_FFFF, "R4");
      for (int i = 0; i < 4; i++) drive(1, 0, 32'h8000_0001, 28'h7FF_FFFF, "R4");
      drive(1, 0, 32'h0000_0100, 28'h000_0003, "R4");
      idle(2);
      chk(acc_out == 60'h300, "R4 exact total", 64'(acc_out), 64'h300);

      // R8 result wraps: bits above 54 set
      drive(1, 1, 32'h7000_0000, 28'h700_0000, "R8");
      drive(1, 0, 32'hFFFF_FFFF, 28'h000_0001, "R8");

      // R10 back-to-back sums
      drive(1, 1, 32'h0000_1000, 28'h000_0010, "R10");
      drive(1, 0, 32'h0000_2000, 28'h000_0010, "R10");
      drive(1, 1, 32'hFFFF_F000, 28'h000_0020, "R10");
      drive(1, 0, 32'h0000_0001, 28'hFFF_FFFF, "R10");
      idle(3);
      chk(exp_q.size() == 0, "R7 all results seen", 64'(exp_q.size()), 64'd0);

      // R9 alignment
      chk_align(2'd0, 24'h00_7FFF);
      chk_align(2'd0, 24'hAB_8000);
      chk_align(2'd1, 24'h02_0001);
      chk_align(2'd1, 24'h01_FFFF);
      chk_align(2'd2, 24'h08_0000);
      chk_align(2'd2, 24'hF7_FFFF);
      chk_align(2'd3, 24'h80_0000);
      chk_align(2'd3, 24'h7F_FFFF);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      chk(1'b0, "watchdog", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule